// File: doc/BRIEF.md
# Beat-Tag Period and Phase Error Detector

This block sits between two beat-frequency edge detectors and two clock-control loops. It receives timestamp tags from two streams. Each tag is a one-cycle strobe with a 32-bit counter value. The first stream comes from the recovered transceiver clock and the second from the main oscillator.

The block turns these tags into two signed error values, each with its own one-cycle valid pulse.

- **Period error (helper loop).** Successive recovered-clock tags are compared with the nominal beat period of 0x4000 counts. The result goes to the helper loop.
- **Phase error (main loop).** The latest recovered-clock tag is paired with the latest main-oscillator tag. Their difference is folded into one beat period and centred on zero. The result goes to the main loop.

An active-low synchronous reset clears all stored tags and pairing state. After reset, the next recovered-clock tag is treated as the first one again.

Top module: `tag_error_detector`

## Requirements
- R1: While reset is asserted, and in the cycle after it, both valid outputs are 0 and both error outputs are 0.
- R2: The first recovered-clock tag after reset only loads the stored tag. It produces no period-error pulse.
- R3: Every later recovered-clock tag, sampled at clock edge k, raises `period_vld` for exactly the cycle after edge k. In that cycle, `period_err` = 0x4000 − (new − stored), computed modulo 2^32 as two's complement. The new tag then becomes the stored tag.
- R4: The tag difference wraps at 32 bits. For example, tags 0xFFFFFFF0 followed by 0x00003FF0 give a period error of 0.
- R5: A phase result is issued once both a recovered-clock tag and a main tag have arrived since the previous phase result. If the later of the two is sampled at edge k, `phase_vld` is high for exactly the cycle after edge k+1.
- R6: The phase result is computed in four steps.
  1. d = (main tag − recovered tag) mod 2^32.
  2. m = d mod 0x4000.
  3. If m > 0x2000, the output is m − 0x4000; otherwise it is m.
  4. The output is 32-bit two's complement, so it lies in (−0x2000, 0x2000].
- R7: Issuing a phase result clears both arrival flags together. Further tags on only one stream produce no phase result. The pairing always uses the most recent tag of each stream.
- R8: Strobes on both streams in the same cycle are both captured. The phase result follows one cycle later.
- R9: A reset during operation discards any pending arrivals and restores the first-tag condition.
- R10: The period and phase outputs are independent and may be valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_tag_stb | input | 1 | Recovered-clock tag strobe |
| rx_tag | input | 32 | Recovered-clock tag value |
| osc_tag_stb | input | 1 | Main-oscillator tag strobe |
| osc_tag | input | 32 | Main-oscillator tag value |
| period_err | output | 32 | Signed period error |
| period_vld | output | 1 | One-cycle valid pulse for `period_err` |
| phase_err | output | 32 | Signed phase error |
| phase_vld | output | 1 | One-cycle valid pulse for `phase_err` |

## Verification
The bench covers the following corner cases:

- **First tag after reset.** A design that ignored the first-tag rule would emit a large bogus period error against a zero stored tag.
- **Counter rollover.** Tags that straddle the 32-bit wrap would yield a huge error if the subtraction were not modular.
- **Phase fold boundary.** Folded values of exactly 0x2000 and 0x2001 check that the re-centring uses a strict greater-than. A wrong comparison flips the sign at half a period.
- **Pairing rules.** Repeated single-stream tags check that a result appears only after both flags are set and that the freshest tags are used. Stale pairing or one-sided clearing would produce extra or shifted phase pulses.
- **Simultaneous strobes and mid-run reset.** These check that neither arrival is lost and that reset discards pending state.

// File: rtl/tagdet_pkg.sv
// Package: shared sizing constants for the beat-tag error detector.
// Assumes the beat period is a power of two counts.
package tagdet_pkg;
    localparam int TAG_W_DEF     = 32;  // tag counter width
    localparam int BEAT_LOG2_DEF = 14;  // beat period = 2**BEAT_LOG2 counts
endpackage

// File: rtl/tagdet_period.sv
// Module: tagdet_period
// Tracks successive recovered-clock tags and emits the deviation of each
// interval from the nominal beat period. The first tag after reset only
// seeds the stored tag. Assumes tag_stb is a single-cycle strobe.
module tagdet_period #(
    parameter int TAG_W     = tagdet_pkg::TAG_W_DEF,
    parameter int BEAT_LOG2 = tagdet_pkg::BEAT_LOG2_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tag_stb,
    input  logic [TAG_W-1:0] tag,
    output logic [TAG_W-1:0] err,
    output logic             err_vld
);
    localparam logic [TAG_W-1:0] BEAT = {{(TAG_W-1){1'b0}}, 1'b1} << BEAT_LOG2;

    logic             first_q;
    logic [TAG_W-1:0] held_q;

    // Purpose: hold latest tag and produce a registered period error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            held_q  <= '0;
            err     <= '0;
            err_vld <= 1'b0;
        end else begin
            err_vld <= 1'b0;
            if (tag_stb) begin
                held_q  <= tag;
                first_q <= 1'b0;
                if (!first_q) begin
                    err_vld <= 1'b1;
                    err     <= BEAT - (tag - held_q);
                end
            end
        end
    end

    // R2: a seeding tag must not produce a result
    assert_first_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_stb && first_q) |=> !err_vld);

    // R3: a result only follows a strobe
    assert_vld_after_stb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld |-> $past(tag_stb));
endmodule

// File: rtl/tagdet_phase.sv
// Module: tagdet_phase
// Pairs the most recent tag of each stream. Once both have arrived since
// the last result, it emits their difference folded into one beat period
// and centred on zero. Assumes single-cycle strobes.
module tagdet_phase #(
    parameter int TAG_W     = tagdet_pkg::TAG_W_DEF,
    parameter int BEAT_LOG2 = tagdet_pkg::BEAT_LOG2_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_stb,
    input  logic [TAG_W-1:0] rx_tag,
    input  logic             osc_stb,
    input  logic [TAG_W-1:0] osc_tag,
    output logic [TAG_W-1:0] err,
    output logic             err_vld
);
    localparam logic [TAG_W-1:0] BEAT = {{(TAG_W-1){1'b0}}, 1'b1} << BEAT_LOG2;
    localparam logic [TAG_W-1:0] HALF = BEAT >> 1;
    localparam logic [TAG_W-1:0] MASK = BEAT - 1'b1;

    logic             rx_rdy_q, osc_rdy_q;
    logic [TAG_W-1:0] rx_q, osc_q;
    logic [TAG_W-1:0] diff, folded, centred;
    logic             fire;

    // Purpose: fold the wrapped tag difference into a signed half-period range.
    always_comb begin
        diff    = osc_q - rx_q;
        folded  = diff & MASK;
        centred = (folded > HALF) ? (folded - BEAT) : folded;
        fire    = rx_rdy_q && osc_rdy_q;
    end

    // Purpose: capture tags, track arrivals, register the phase result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q      <= '0;
            osc_q     <= '0;
            rx_rdy_q  <= 1'b0;
            osc_rdy_q <= 1'b0;
            err       <= '0;
            err_vld   <= 1'b0;
        end else begin
            err_vld   <= fire;
            if (fire) err <= centred;
            rx_rdy_q  <= rx_stb  || (rx_rdy_q  && !fire);
            osc_rdy_q <= osc_stb || (osc_rdy_q && !fire);
            if (rx_stb)  rx_q  <= rx_tag;
            if (osc_stb) osc_q <= osc_tag;
        end
    end

    // R5: a result needs both arrivals in the previous cycle
    assert_pair_needed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld |-> $past(rx_rdy_q && osc_rdy_q));

    // R6: result lies in (-HALF, HALF]
    assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld |-> (($signed(err) <= $signed(HALF)) && ($signed(err) > -$signed(HALF))));

    // R7: both flags drop together after a result when nothing new arrives
    assert_flags_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rdy_q && osc_rdy_q && !rx_stb && !osc_stb) |=> (!rx_rdy_q && !osc_rdy_q));
endmodule

// File: rtl/tag_error_detector.sv
// Module: tag_error_detector (top)
// Converts recovered-clock and main-oscillator beat tags into a period error
// (helper loop) and a phase error (main loop), each with a one-cycle valid.
// Assumes tags are free-running counters wrapping at TAG_W bits.
module tag_error_detector #(
    parameter int TAG_W     = tagdet_pkg::TAG_W_DEF,
    parameter int BEAT_LOG2 = tagdet_pkg::BEAT_LOG2_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_tag_stb,
    input  logic [TAG_W-1:0] rx_tag,
    input  logic             osc_tag_stb,
    input  logic [TAG_W-1:0] osc_tag,
    output logic [TAG_W-1:0] period_err,
    output logic             period_vld,
    output logic [TAG_W-1:0] phase_err,
    output logic             phase_vld
);
    tagdet_period #(.TAG_W(TAG_W), .BEAT_LOG2(BEAT_LOG2)) u_period (
        .clk(clk), .rst_n(rst_n),
        .tag_stb(rx_tag_stb), .tag(rx_tag),
        .err(period_err), .err_vld(period_vld)
    );

    tagdet_phase #(.TAG_W(TAG_W), .BEAT_LOG2(BEAT_LOG2)) u_phase (
        .clk(clk), .rst_n(rst_n),
        .rx_stb(rx_tag_stb), .rx_tag(rx_tag),
        .osc_stb(osc_tag_stb), .osc_tag(osc_tag),
        .err(phase_err), .err_vld(phase_vld)
    );

    // R1: outputs quiet in the cycle after a reset edge
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!period_vld && !phase_vld && period_err == '0 && phase_err == '0));
endmodule

// File: tb/tb_tag_error_detector.sv
`timescale 1ns/1ps
module tb_tag_error_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_tag_stb = 1'b0, osc_tag_stb = 1'b0;
    logic [31:0] rx_tag = '0, osc_tag = '0;
    logic [31:0] period_err, phase_err;
    logic        period_vld, phase_vld;

    int total = 0, bad = 0;
    bit started = 0, done = 0;

    always #2.5 clk = ~clk;

    tag_error_detector dut (
        .clk(clk), .rst_n(rst_n),
        .rx_tag_stb(rx_tag_stb), .rx_tag(rx_tag),
        .osc_tag_stb(osc_tag_stb), .osc_tag(osc_tag),
        .period_err(period_err), .period_vld(period_vld),
        .phase_err(phase_err), .phase_vld(phase_vld)
    );

    function automatic logic [31:0] ref_phase(logic [31:0] o, logic [31:0] r);
        logic [31:0] d;
        int m;
        d = o - r;
        m = int'(d % 32'd16384);
        if (m > 8192) m = m - 16384;
        return 32'(m);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: behavioural, updated on each rising edge
    bit          m_first = 1, m_rr = 0, m_or = 0;
    logic [31:0] m_last = '0, m_rx = '0, m_osc = '0;
    bit          e_pv = 0, e_hv = 0;
    logic [31:0] e_pe = '0, e_he = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_first = 1; m_rr = 0; m_or = 0;
            m_last = '0; m_rx = '0; m_osc = '0;
            e_pv = 0; e_hv = 0; e_pe = '0; e_he = '0;
        end else begin
            e_pv = 0;
            if (rx_tag_stb) begin
                if (!m_first) begin
                    e_pv = 1;
                    e_pe = 32'h4000 - (rx_tag - m_last);
                end
                m_first = 0;
                m_last  = rx_tag;
            end
            e_hv = 0;
            if (m_rr && m_or) begin
                e_hv = 1;
                e_he = ref_phase(m_osc, m_rx);
                m_rr = 0; m_or = 0;
            end
            if (rx_tag_stb)  begin m_rx  = rx_tag;  m_rr = 1; end
            if (osc_tag_stb) begin m_osc = osc_tag; m_or = 1; end
        end
        started = 1;
    end

    // per-cycle comparison against the model (R3 R5 R6 R10)
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R3 period_vld", {31'd0, period_vld}, {31'd0, e_pv});
            if (e_pv) chk("R3 period_err", period_err, e_pe);
            chk("R5 phase_vld", {31'd0, phase_vld}, {31'd0, e_hv});
            if (e_hv) chk("R6 phase_err", phase_err, e_he);
        end
    end

    task automatic send_rx(logic [31:0] v);
        @(negedge clk); rx_tag_stb = 1; rx_tag = v;
        @(negedge clk); rx_tag_stb = 0;
    endtask
    task automatic send_osc(logic [31:0] v);
        @(negedge clk); osc_tag_stb = 1; osc_tag = v;
        @(negedge clk); osc_tag_stb = 0;
    endtask
    task automatic send_both(logic [31:0] r, logic [31:0] o);
        @(negedge clk); rx_tag_stb = 1; rx_tag = r; osc_tag_stb = 1; osc_tag = o;
        @(negedge clk); rx_tag_stb = 0; osc_tag_stb = 0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 period_vld", {31'd0, period_vld}, 32'd0);
        chk("R1 phase_vld", {31'd0, phase_vld}, 32'd0);
        chk("R1 period_err", period_err, 32'd0);
        chk("R1 phase_err", phase_err, 32'd0);
        rst_n = 1;

        // R2: first tag is silent
        send_rx(32'd100);
        chk("R2 no period on first tag", {31'd0, period_vld}, 32'd0);

        // R3: interval 0x4000-5 gives +5, single-cycle pulse
        send_rx(32'd100 + 32'h4000 - 32'd5);
        chk("R3 vld", {31'd0, period_vld}, 32'd1);
        chk("R3 err", period_err, 32'd5);
        @(negedge clk);
        chk("R3 single pulse", {31'd0, period_vld}, 32'd0);

        // R3: long interval gives negative error
        send_rx(32'd100 + 32'h4000 - 32'd5 + 32'h4010);
        chk("R3 negative err", period_err, -32'sd16);

        // R5 R6: osc after rx; fold above half period
        send_osc(32'd100 + 32'h4000 - 32'd5 + 32'h4010 + 32'h2001);
        chk("R5 not yet", {31'd0, phase_vld}, 32'd0);
        @(negedge clk);
        chk("R5 phase vld", {31'd0, phase_vld}, 32'd1);
        chk("R6 fold 0x2001", phase_err, 32'hFFFF_E001);

        // R7: osc alone twice -> no result; then rx pairs with latest osc
        send_osc(32'h0001_0000);
        send_osc(32'h0001_2000);
        repeat (2) @(negedge clk);
        chk("R7 one-sided no result", {31'd0, phase_vld}, 32'd0);
        send_rx(32'h0001_0000);
        @(negedge clk);
        chk("R7 latest osc used", phase_err, 32'h0000_2000);

        // R4: wrap of the tag counter
        send_rx(32'hFFFF_FFF0);
        send_rx(32'h0000_3FF0);
        chk("R4 wrap err zero", period_err, 32'd0);
        send_rx(32'h0000_3FF8);
        chk("R4 short interval", period_err, 32'h0000_3FF8);

        // R8 R10: simultaneous strobes, both outputs may coincide
        repeat (2) @(negedge clk);
        send_both(32'h0000_4000, 32'h0000_3FFF);
        chk("R10 period alongside", {31'd0, period_vld}, 32'd1);
        @(negedge clk);
        chk("R8 phase one cycle later", {31'd0, phase_vld}, 32'd1);
        chk("R8 phase err", phase_err, 32'hFFFF_FFFF);

        // R9: reset mid-run clears pending and first-tag condition
        send_rx(32'h0000_8000);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        send_osc(32'h0000_0123);
        repeat (2) @(negedge clk);
        chk("R9 pending rx discarded", {31'd0, phase_vld}, 32'd0);
        send_rx(32'h0000_C000);
        chk("R9 first tag again", {31'd0, period_vld}, 32'd0);

        // mixed traffic, compared by the per-cycle model
        for (int i = 0; i < 40; i++) begin
            if (i % 3 == 0) send_both(32'h0010_0000 + 32'(i * 16381), 32'(i * 7919));
            else if (i % 3 == 1) send_rx(32'h0010_0000 + 32'(i * 16390));
            else send_osc(32'hFFFF_F000 + 32'(i * 4099));
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule